// File: doc/BRIEF.md
# Two-Core Peripheral Interrupt Router

This block sits between a bank of peripheral interrupt lines and the interrupt controllers of two processor cores. For each source it holds a small routing register with one enable bit per core. A source is passed to core 0, to core 1, to both or to neither, and each core receives its own registered interrupt vector. Reset leaves every source unrouted, so software has to program the router before any interrupt can reach a core. This holds even when only one core is present.

Software reaches the router through a 16-bit register port. Each access carries an address, a write strobe and a one-bit tag naming the core that issues it. An identity register returns the tag of the accessing core, so a driver can route a source to whichever core it runs on without knowing that in advance. A two-state read machine handles the port. In `RD_IDLE` no read data is pending. A read request moves it to `RD_RESP` (transition "read accepted"), and the data is valid there for one cycle. From `RD_RESP` a further read stays in `RD_RESP` (transition "back-to-back read"). Anything else returns it to `RD_IDLE` (transition "response done").

Top module: `irq_route_top`

## Requirements
- R1: After reset every routing register reads zero, both core vectors are all zero and the read-valid output is low.
- R2: The routing register for source n is at byte address 0x80 + 2*n, for n from 0 to 111. Its bit 0 enables core 0, so with only bit 0 set the source appears on the core 0 vector and not on the core 1 vector.
- R3: With only bit 1 of a source's routing register set, the source appears on the core 1 vector and not on the core 0 vector.
- R4: With both bits 0 and 1 set, the source appears on both core vectors. This holds for the first source and for the last source (n = 111).
- R5: Writing zero to a routing register stops that source from reaching either core.
- R6: Bits 15:2 of every routing register read as zero, and writes to those bits are ignored.
- R7: A read of byte address 0x4 returns the accessing core's one-bit tag in bit 0, with all other bits zero.
- R8: Read data and the read-valid strobe appear exactly one cycle after the read request, and the strobe lasts one cycle per request.
- R9: An access to an address that is not defined (an odd address, an address past the last routing register, or any other unused address) reads as zero and changes no routing state.
- R10: Bit n of the core k vector equals source n ANDed with enable bit k of register n, as sampled at the previous clock edge. The output is registered and changes one cycle after its inputs.
- R11: A write to the identity register at 0x4 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req_i | input | 1 | Register access request, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 9 | Byte address of the access |
| reg_wdata_i | input | 16 | Write data |
| reg_core_id_i | input | 1 | Tag of the core issuing the access |
| reg_rdata_o | output | 16 | Read data, valid while reg_rvalid_o is high |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_src_i | input | 112 | Peripheral interrupt lines |
| core0_irq_o | output | 112 | Registered interrupt vector for core 0 |
| core1_irq_o | output | 112 | Registered interrupt vector for core 1 |

## Verification
A routing bit that is corrupted or written to the wrong index shows on the core vectors one clock after any cycle in which that source is active. It also shows in the read data of the next access to that register. The bench therefore keeps the sources busy with changing patterns and compares both vectors against its own model on every clock. A fault in the read machine shows as a strobe or data word that is missing, late or repeated in the cycle after a request. Decode faults that touch undefined addresses show as non-zero read data, or as a routing change that appears at the outputs one cycle later.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    // Number of cores served by the router.
    localparam int unsigned CORES = 2;

    // Read-port machine states.
    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 112,
    parameter int unsigned NUM_CORE   = 2,
    parameter int unsigned ADDR_W     = 9,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ROUTE_BASE = 'h80,
    parameter int unsigned ID_ADDR    = 'h4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              core_id,
    output logic [DATA_W-1:0]                 rdata,
    output logic                              rvalid,
    output logic [NUM_CORE-1:0][NUM_SRC-1:0]  en_o
);
    localparam int unsigned IDX_W = $clog2(NUM_SRC);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(ROUTE_BASE);
    localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(ROUTE_BASE + 2 * NUM_SRC);
    localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_ADDR);

    logic             route_hit;
    logic             id_hit;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] rd_next;
    logic             unused_wdata_hi;
    rd_state_e        state_q, state_d;

    // Address decode: only even addresses inside the routing window are defined.
    always_comb begin
        route_hit = (addr >= BASE_A) && (addr < END_A) && !addr[0];
        id_hit    = (addr == ID_A);
        idx       = IDX_W'((addr - BASE_A) >> 1);
    end

    assign unused_wdata_hi = ^wdata[DATA_W-1:NUM_CORE];

    // Per-source routing storage.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int k = 0; k < NUM_CORE; k++) en_o[k][n] <= 1'b0;
            end else if (req && we && route_hit && (idx == IDX_W'(n))) begin
                for (int k = 0; k < NUM_CORE; k++) en_o[k][n] <= wdata[k];
            end
        end
    end

    // Read data selection.
    always_comb begin
        rd_next = '0;
        if (id_hit) begin
            rd_next = DATA_W'(core_id);
        end else if (route_hit) begin
            for (int k = 0; k < NUM_CORE; k++) rd_next[k] = en_o[k][idx];
        end
    end

    // Read machine: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // Read machine: transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (req && !we) state_d = RD_RESP;   // read accepted
            RD_RESP: if (req && !we) state_d = RD_RESP;   // back-to-back read
                     else            state_d = RD_IDLE;   // response done
            default: state_d = RD_IDLE;
        endcase
    end

    // Read machine: outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            rdata <= '0;
        else if (req && !we)   rdata <= rd_next;
    end

    assign rvalid = (state_q == RD_RESP);

    p_rd_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rvalid);

    p_rvalid_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(req && !we));

    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rdata[DATA_W-1:NUM_CORE] == '0));

    p_undef_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && !route_hit && !id_hit) |=> (rdata == '0));
endmodule

// File: rtl/irq_route_fanout.sv
module irq_route_fanout #(
    parameter int unsigned NUM_SRC  = 112,
    parameter int unsigned NUM_CORE = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SRC-1:0]                src,
    input  logic [NUM_CORE-1:0][NUM_SRC-1:0]  en,
    output logic [NUM_CORE-1:0][NUM_SRC-1:0]  irq_q
);
    for (genvar k = 0; k < NUM_CORE; k++) begin : g_core
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q[k] <= '0;
            else        irq_q[k] <= src & en[k];
        end

        p_needs_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_q[k] & ~$past(src)) == '0);

        p_needs_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_q[k] & ~$past(en[k])) == '0);
    end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 112,
    parameter int unsigned ADDR_W     = 9,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ROUTE_BASE = 'h80,
    parameter int unsigned ID_ADDR    = 'h4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_req_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    input  logic               reg_core_id_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               reg_rvalid_o,
    input  logic [NUM_SRC-1:0] irq_src_i,
    output logic [NUM_SRC-1:0] core0_irq_o,
    output logic [NUM_SRC-1:0] core1_irq_o
);
    logic [CORES-1:0][NUM_SRC-1:0] en;
    logic [CORES-1:0][NUM_SRC-1:0] irq_q;

    irq_route_regs #(
        .NUM_SRC(NUM_SRC), .NUM_CORE(CORES), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .ROUTE_BASE(ROUTE_BASE), .ID_ADDR(ID_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .req(reg_req_i), .we(reg_we_i),
        .addr(reg_addr_i), .wdata(reg_wdata_i), .core_id(reg_core_id_i),
        .rdata(reg_rdata_o), .rvalid(reg_rvalid_o), .en_o(en)
    );

    irq_route_fanout #(.NUM_SRC(NUM_SRC), .NUM_CORE(CORES)) u_fanout (
        .clk(clk), .rst_n(rst_n), .src(irq_src_i), .en(en), .irq_q(irq_q)
    );

    assign core0_irq_o = irq_q[0];
    assign core1_irq_o = irq_q[1];

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (core0_irq_o == '0 && core1_irq_o == '0));
endmodule

// File: tb/irq_route_top_tb_top.sv
module irq_route_top_tb_top;
    localparam int NS = 112;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, we = 1'b0, cid = 1'b0;
    logic [8:0]    addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          rvalid;
    logic [NS-1:0] src = '0;
    logic [NS-1:0] c0, c1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_route_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_req_i(req), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_core_id_i(cid),
        .reg_rdata_o(rdata), .reg_rvalid_o(rvalid), .irq_src_i(src),
        .core0_irq_o(c0), .core1_irq_o(c1)
    );

    // Behavioural reference model.
    int            route_m [NS];
    logic [NS-1:0] exp_c0 = '0, exp_c1 = '0;
    logic          exp_rv = 1'b0;
    logic [15:0]   exp_rd = '0;

    function automatic int decode(input logic [8:0] a);
        int ai = int'(a);
        if (ai >= 128 && ai < 128 + 2 * NS && (ai % 2) == 0) return (ai - 128) / 2;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NS; n++) route_m[n] <= 0;
            exp_c0 <= '0; exp_c1 <= '0; exp_rv <= 1'b0; exp_rd <= '0;
        end else begin
            for (int n = 0; n < NS; n++) begin
                exp_c0[n] <= src[n] && (route_m[n] % 2 == 1);
                exp_c1[n] <= src[n] && (route_m[n] >= 2);
            end
            exp_rv <= req && !we;
            if (req && we && decode(addr) >= 0)
                route_m[decode(addr)] <= int'(wdata) % 4;
            if (req && !we) begin
                if (addr == 9'h4)            exp_rd <= {15'd0, cid};
                else if (decode(addr) >= 0)  exp_rd <= 16'(route_m[decode(addr)]);
                else                         exp_rd <= '0;
            end
        end
    end

    bit compare_on = 0;
    always @(negedge clk) begin
        if (compare_on) begin
            checks++;
            if (c0 !== exp_c0 || c1 !== exp_c1) begin
                errors++;
                $display("FAIL R10 vectors: c0=%h c1=%h expected c0=%h c1=%h", c0, c1, exp_c0, exp_c1);
            end
            checks++;
            if (rvalid !== exp_rv || (exp_rv && rdata !== exp_rd)) begin
                errors++;
                $display("FAIL R8 read port: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                         rvalid, rdata, exp_rv, exp_rd);
            end
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d, input logic id);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; cid = id;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic id, output logic [15:0] d);
        req = 1'b1; we = 1'b0; addr = a; cid = id;
        @(negedge clk);
        req = 1'b0;
        check("R8 rvalid after read", 128'(rvalid), 128'(1));
        d = rdata;
        @(negedge clk);
        check("R8 rvalid single cycle", 128'(rvalid), 128'(0));
    endtask

    function automatic logic [8:0] ra(input int n);
        return 9'(128 + 2 * n);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_on = 1;
        // R1
        check("R1 core0 after reset", 128'(c0), 128'(0));
        check("R1 core1 after reset", 128'(c1), 128'(0));
        check("R1 rvalid after reset", 128'(rvalid), 128'(0));
        rd(ra(5), 1'b0, d);
        check("R1 route reads zero", 128'(d), 128'(0));

        src = '1;
        @(negedge clk);
        check("R1 unrouted source blocked", 128'(c0 | c1), 128'(0));

        // R2
        wr(ra(3), 16'h0001, 1'b0);
        @(negedge clk);
        check("R2 core0 bit", 128'(c0[3]), 128'(1));
        check("R2 core1 bit", 128'(c1[3]), 128'(0));
        // R3
        wr(ra(110), 16'h0002, 1'b1);
        @(negedge clk);
        check("R3 core1 bit", 128'(c1[110]), 128'(1));
        check("R3 core0 bit", 128'(c0[110]), 128'(0));
        // R4
        wr(ra(0), 16'h0003, 1'b0);
        wr(ra(111), 16'h0003, 1'b1);
        @(negedge clk);
        check("R4 first source both", 128'({c0[0], c1[0]}), 128'(3));
        check("R4 last source both", 128'({c0[111], c1[111]}), 128'(3));
        // R5
        wr(ra(3), 16'h0000, 1'b0);
        @(negedge clk);
        check("R5 source unrouted", 128'({c0[3], c1[3]}), 128'(0));
        // R6
        wr(ra(7), 16'hFFFF, 1'b0);
        rd(ra(7), 1'b0, d);
        check("R6 upper bits zero", 128'(d), 128'(3));
        check("R6 both routed", 128'({c0[7], c1[7]}), 128'(3));
        // R7
        rd(9'h004, 1'b0, d);
        check("R7 id core0", 128'(d), 128'(0));
        rd(9'h004, 1'b1, d);
        check("R7 id core1", 128'(d), 128'(1));
        // R11
        wr(9'h004, 16'h0001, 1'b0);
        rd(9'h004, 1'b0, d);
        check("R11 id write ignored", 128'(d), 128'(0));
        // R9
        wr(9'h083, 16'h0003, 1'b0);
        wr(9'h160, 16'h0003, 1'b0);
        wr(9'h002, 16'h0003, 1'b0);
        @(negedge clk);
        check("R9 odd write no effect", 128'({c0[1], c1[1]}), 128'(0));
        rd(ra(1), 1'b0, d);
        check("R9 neighbour unchanged", 128'(d), 128'(0));
        rd(9'h083, 1'b0, d);
        check("R9 odd reads zero", 128'(d), 128'(0));
        rd(9'h160, 1'b0, d);
        check("R9 past end reads zero", 128'(d), 128'(0));
        rd(9'h002, 1'b1, d);
        check("R9 unused reads zero", 128'(d), 128'(0));
        // R8 back-to-back reads
        req = 1'b1; we = 1'b0; addr = ra(0); cid = 1'b0;
        @(negedge clk);
        check("R8 first of pair", 128'({rvalid, rdata}), 128'({1'b1, 16'h3}));
        addr = ra(110);
        @(negedge clk);
        req = 1'b0;
        check("R8 second of pair", 128'({rvalid, rdata}), 128'({1'b1, 16'h2}));
        @(negedge clk);
        check("R8 strobe ends", 128'(rvalid), 128'(0));
        // R10: one-cycle latency
        src[0] = 1'b0;
        #1;
        check("R10 output holds before edge", 128'(c0[0]), 128'(1));
        @(negedge clk);
        check("R10 output follows after edge", 128'(c0[0]), 128'(0));
        // R10: varied patterns and routes, model compared every clock
        for (int i = 0; i < 400; i++) begin
            src = {$urandom, $urandom, $urandom, $urandom};
            if (i % 3 == 0) wr(ra(int'($urandom % NS)), 16'($urandom), 1'($urandom));
            else @(negedge clk);
        end
        src = '0;
        @(negedge clk);
        check("R10 quiet sources", 128'(c0 | c1), 128'(0));
        compare_on = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule